// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a free-running timer. It watches a counter that lives outside the block and works in one of two modes. In capture mode it samples a pin through a synchronizer and, on the edge type that has been programmed, copies the counter into its channel register. In compare mode it compares the channel register with the counter and, on a match, drives a programmed action onto its output pin.

Both modes report through one shared event flag. The flag raises an interrupt request while the interrupt enable is set. Independently of the mode, the output pin can also toggle on every counter overflow. Software loads the channel register through a write strobe and acknowledges the flag with a clear strobe.

Top module: `tmr_chan_unit`

## Requirements
- R1: While reset is asserted and right after it, flag, irq and pin_out are 0 and chan_reg is all zeros.
- R2: A cycle with reg_we high loads reg_wdata into chan_reg at that clock edge.
- R3: With mode_cmp low, edge_sel selects the capture edge: 00 = none, 01 = rising, 10 = falling, 11 = either. pin_in passes through a two-flop synchronizer. The capture takes place at the third rising clock edge after pin_in changes, and stores the cnt_val that is present in the cycle before that edge.
- R4: A capture sets flag at the same edge that loads chan_reg. A capture overrides a reg_we write in the same cycle.
- R5: With mode_cmp low, cnt_val equal to chan_reg never sets flag, and pin_out changes only through the overflow toggle.
- R6: With mode_cmp high, a match is a cycle in which cnt_tick is high and cnt_val equals chan_reg. A match sets flag at the next edge. Edges on pin_in neither capture nor set flag.
- R7: On a match, out_act drives pin_out at the same edge that sets flag: 00 = unchanged, 01 = toggle, 10 = drive 0, 11 = drive 1.
- R8: When tog_ovf_en and ovf_tick are both high in a cycle, pin_out inverts at that edge. When tog_ovf_en is low, ovf_tick has no effect.
- R9: A match with out_act not equal to 00 takes priority over an overflow toggle in the same cycle. A match with out_act 00 lets the toggle through.
- R10: A cycle with cnt_tick low produces no match, even when cnt_val equals chan_reg.
- R11: flag stays set until a cycle with flag_clr high. A set and a clear in the same cycle leave flag set.
- R12: irq equals flag AND irq_en, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter presented a new value this cycle |
| ovf_tick | input | 1 | Counter wrapped this cycle |
| mode_cmp | input | 1 | 1 = compare mode, 0 = capture mode |
| edge_sel | input | 2 | Capture edge select |
| out_act | input | 2 | Pin action on compare match |
| tog_ovf_en | input | 1 | Toggle pin on counter overflow |
| irq_en | input | 1 | Interrupt enable |
| reg_we | input | 1 | Channel register write strobe |
| reg_wdata | input | 16 | Channel register write data |
| flag_clr | input | 1 | Flag clear strobe |
| pin_in | input | 1 | Asynchronous channel pin input |
| pin_out | output | 1 | Channel pin output |
| chan_reg | output | 16 | Channel register value |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the ones where two events land on the same clock edge: a capture together with a register write, a match together with a flag clear, and a match together with an overflow toggle. The bench has a fixed count of synchronizer cycles. It uses that count to place a write strobe exactly in the cycle where the synchronized edge is live. It presents the matching counter value with the tick and the overflow strobe raised in the same cycle. The action sweep first forces the pin to each starting level with a preparatory match, so that toggle, drive-0 and drive-1 can each be told apart from the others.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } out_act_e;

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge
  import tmr_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;
  logic            lvl_now;
  logic            lvl_prev;
  logic            rise;
  logic            fall;
  edge_sel_e       sel;

  // stage 0 is the first synchronizer flop; the last stage holds the
  // previous synchronized level for edge detection
  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    lvl_now  = sh_q[SYNC_STAGES-1];
    lvl_prev = sh_q[SYNC_STAGES];
    rise     = lvl_now & ~lvl_prev;
    fall     = ~lvl_now & lvl_prev;
    sel      = edge_sel_e'(edge_sel);
    unique case (sel)
      EDGE_OFF:  edge_hit = 1'b0;
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] chan_reg,
  input  logic             cnt_tick,
  input  logic             mode_cmp,
  output logic             match
);

  logic [CNT_W-1:0] bit_eq;

  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_eq
      assign bit_eq[gi] = ~(cnt_val[gi] ^ chan_reg[gi]);
    end
  endgenerate

  always_comb begin
    match = mode_cmp & cnt_tick & (&bit_eq);
  end

endmodule

// File: rtl/tmr_chan_pin.sv
module tmr_chan_pin
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match,
  input  logic [1:0] out_act,
  input  logic       ovf_tick,
  input  logic       tog_ovf_en,
  output logic       pin_out
);

  logic     pin_q;
  logic     pin_d;
  logic     pin_en;
  out_act_e act;

  always_comb begin
    act    = out_act_e'(out_act);
    pin_d  = pin_q;
    pin_en = 1'b0;
    if (match && act != ACT_NONE) begin
      pin_en = 1'b1;
      unique case (act)
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end else if (ovf_tick && tog_ovf_en) begin
      pin_en = 1'b1;
      pin_d  = ~pin_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_out = pin_q;

endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_tick,
  input  logic             ovf_tick,
  input  logic             mode_cmp,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       out_act,
  input  logic             tog_ovf_en,
  input  logic             irq_en,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             flag_clr,
  input  logic             pin_in,
  output logic             pin_out,
  output logic [CNT_W-1:0] chan_reg,
  output logic             flag,
  output logic             irq
);

  logic             edge_hit;
  logic             cap_evt;
  logic             match;
  logic [CNT_W-1:0] reg_q;
  logic [CNT_W-1:0] reg_d;
  logic             reg_en;
  logic             flag_q;
  logic             flag_d;

  tmr_chan_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  tmr_chan_match #(
    .CNT_W(CNT_W)
  ) u_match (
    .cnt_val  (cnt_val),
    .chan_reg (reg_q),
    .cnt_tick (cnt_tick),
    .mode_cmp (mode_cmp),
    .match    (match)
  );

  tmr_chan_pin u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .match      (match),
    .out_act    (out_act),
    .ovf_tick   (ovf_tick),
    .tog_ovf_en (tog_ovf_en),
    .pin_out    (pin_out)
  );

  // capture has priority over a software write in the same cycle
  always_comb begin
    cap_evt = edge_hit & ~mode_cmp;
    reg_en  = cap_evt | reg_we;
    reg_d   = cap_evt ? cnt_val : reg_wdata;
  end

  // a set event outranks the clear strobe
  always_comb begin
    if (cap_evt || match) flag_d = 1'b1;
    else if (flag_clr)    flag_d = 1'b0;
    else                  flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign chan_reg = reg_q;
  assign flag     = flag_q;
  assign irq      = flag_q & irq_en;

endmodule

// File: rtl/tmr_chan_unit_chk.sv
module tmr_chan_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_tick,
  input logic             ovf_tick,
  input logic             mode_cmp,
  input logic [1:0]       edge_sel,
  input logic [1:0]       out_act,
  input logic             reg_we,
  input logic             flag_clr,
  input logic             pin_out,
  input logic [CNT_W-1:0] chan_reg,
  input logic             flag,
  input logic             irq
);

  // R12: no request without a pending flag
  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  // R11: clear with no possible set source empties the flag
  a_r11_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mode_cmp && edge_sel == 2'b00) |=> !flag);

  // R6 / R2: in compare mode the register moves only on a write
  a_r6_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && !reg_we) |=> $stable(chan_reg));

  // R10: no tick, no new flag in compare mode
  a_r10_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && !cnt_tick && !flag) |=> !flag);

  // R5: in capture mode the pin moves only on overflow
  a_r5_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cmp && !ovf_tick) |=> $stable(pin_out));

  // R9: a clear action wins against a simultaneous overflow toggle
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && cnt_tick && cnt_val == chan_reg && out_act == 2'b10) |=> !pin_out);

  // R7: a set action drives the pin high
  a_r7_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && cnt_tick && cnt_val == chan_reg && out_act == 2'b11) |=> (pin_out && flag));

endmodule

bind tmr_chan_unit tmr_chan_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_val  (cnt_val),
  .cnt_tick (cnt_tick),
  .ovf_tick (ovf_tick),
  .mode_cmp (mode_cmp),
  .edge_sel (edge_sel),
  .out_act  (out_act),
  .reg_we   (reg_we),
  .flag_clr (flag_clr),
  .pin_out  (pin_out),
  .chan_reg (chan_reg),
  .flag     (flag),
  .irq      (irq)
);

// File: tb/tb_tmr_chan_unit.sv
`timescale 1ns/1ps
module tb_tmr_chan_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        cnt_tick;
  logic        ovf_tick;
  logic        mode_cmp;
  logic [1:0]  edge_sel;
  logic [1:0]  out_act;
  logic        tog_ovf_en;
  logic        irq_en;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic        flag_clr;
  logic        pin_in;
  logic        pin_out;
  logic [15:0] chan_reg;
  logic        flag;
  logic        irq;

  int checks;
  int errors;

  tmr_chan_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .ovf_tick(ovf_tick), .mode_cmp(mode_cmp), .edge_sel(edge_sel),
    .out_act(out_act), .tog_ovf_en(tog_ovf_en), .irq_en(irq_en),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .flag_clr(flag_clr),
    .pin_in(pin_in), .pin_out(pin_out), .chan_reg(chan_reg),
    .flag(flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(input logic [15:0] v, input logic tk, input logic ov);
    cnt_val  = v;
    cnt_tick = tk;
    ovf_tick = ov;
    @(negedge clk);
    cnt_tick = 1'b0;
    ovf_tick = 1'b0;
    reg_we   = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_we    = 1'b1;
    reg_wdata = d;
    step(cnt_val, 1'b0, 1'b0);
    chk("R2 write", chan_reg, d);
  endtask

  task automatic clr();
    flag_clr = 1'b1;
    step(cnt_val, 1'b0, 1'b0);
  endtask

  task automatic do_match(input logic [15:0] m, input logic [1:0] a);
    out_act = a;
    wr(m);
    clr();
    step(m - 16'd1, 1'b1, 1'b0);
    chk("R6 no match before", {15'd0, flag}, 16'd0);
    step(m, 1'b1, 1'b0);
    chk("R6 match sets flag", {15'd0, flag}, 16'd1);
  endtask

  task automatic cap(input logic [1:0] es, input logic rise, input logic [15:0] b);
    logic hit;
    edge_sel = 2'b00;
    pin_in   = ~rise;
    repeat (4) step(cnt_val, 1'b0, 1'b0);
    clr();
    wr(16'hDEAD);
    edge_sel = es;
    pin_in   = rise;
    step(b, 1'b0, 1'b0);
    step(b + 16'd1, 1'b0, 1'b0);
    chk("R3 not yet captured", {15'd0, flag}, 16'd0);
    step(b + 16'd2, 1'b0, 1'b0);
    hit = (es == 2'b11) || (es == 2'b01 && rise) || (es == 2'b10 && !rise);
    chk("R3 capture flag", {15'd0, flag}, {15'd0, hit});
    chk("R3 capture value", chan_reg, hit ? b + 16'd2 : 16'hDEAD);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; cnt_val = '0; cnt_tick = 0; ovf_tick = 0; mode_cmp = 0;
    edge_sel = 0; out_act = 0; tog_ovf_en = 0; irq_en = 0; reg_we = 0;
    reg_wdata = '0; flag_clr = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset flag", {15'd0, flag}, 16'd0);
    chk("R1 reset pin", {15'd0, pin_out}, 16'd0);
    chk("R1 reset reg", chan_reg, 16'd0);
    chk("R1 reset irq", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release flag", {15'd0, flag}, 16'd0);

    // capture sweep: every edge selection against both edge directions
    for (int es = 0; es < 4; es++)
      for (int r = 0; r < 2; r++)
        cap(es[1:0], r[0], 16'h2000 + 16'(es * 16 + r * 4));

    // R4: capture beats same-cycle write
    edge_sel = 2'b00; pin_in = 1'b0;
    repeat (4) step(cnt_val, 1'b0, 1'b0);
    clr();
    edge_sel = 2'b01; pin_in = 1'b1;
    step(16'h3000, 1'b0, 1'b0);
    step(16'h3001, 1'b0, 1'b0);
    reg_we = 1'b1; reg_wdata = 16'h5555;
    step(16'h3002, 1'b0, 1'b0);
    chk("R4 capture over write", chan_reg, 16'h3002);
    chk("R4 capture sets flag", {15'd0, flag}, 16'd1);

    // R5: capture mode ignores equality
    edge_sel = 2'b00;
    clr();
    wr(16'h4444);
    out_act = 2'b11;
    step(16'h4444, 1'b1, 1'b0);
    step(16'h4444, 1'b1, 1'b0);
    chk("R5 no match in capture mode", {15'd0, flag}, 16'd0);
    chk("R5 pin unchanged", {15'd0, pin_out}, 16'd0);

    // R6: compare mode ignores pin edges
    mode_cmp = 1'b1; edge_sel = 2'b11;
    pin_in = ~pin_in;
    repeat (4) step(16'h0001, 1'b0, 1'b0);
    chk("R6 edge ignored flag", {15'd0, flag}, 16'd0);
    chk("R6 edge ignored reg", chan_reg, 16'h4444);
    edge_sel = 2'b00;

    // R7 sweep over start level and action
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 4; a++) begin
        logic expv;
        do_match(16'h0100 + 16'(p * 64 + a * 8), p ? 2'b11 : 2'b10);
        chk("R7 preset level", {15'd0, pin_out}, 16'(p));
        do_match(16'h8000 + 16'(p * 64 + a * 8), a[1:0]);
        expv = (a == 0) ? p[0] : (a == 1) ? ~p[0] : (a == 2) ? 1'b0 : 1'b1;
        chk("R7 action result", {15'd0, pin_out}, {15'd0, expv});
      end

    // boundary value match
    do_match(16'hFFFF, 2'b11);
    chk("R7 top value set", {15'd0, pin_out}, 16'd1);

    // R10: held equal value without tick
    clr();
    repeat (3) step(16'hFFFF, 1'b0, 1'b0);
    chk("R10 no tick no flag", {15'd0, flag}, 16'd0);

    // R11: set beats clear, then hold, then clear
    out_act = 2'b00;
    wr(16'h0A0A);
    step(16'h0A09, 1'b1, 1'b0);
    flag_clr = 1'b1;
    step(16'h0A0A, 1'b1, 1'b0);
    chk("R11 set wins", {15'd0, flag}, 16'd1);
    repeat (2) step(16'h0A0B, 1'b1, 1'b0);
    chk("R11 flag holds", {15'd0, flag}, 16'd1);

    // R12
    irq_en = 1'b0; #1;
    chk("R12 irq masked", {15'd0, irq}, 16'd0);
    irq_en = 1'b1; #1;
    chk("R12 irq raised", {15'd0, irq}, 16'd1);
    @(negedge clk);
    clr();
    chk("R11 cleared", {15'd0, flag}, 16'd0);
    chk("R12 irq drops", {15'd0, irq}, 16'd0);

    // R8: overflow toggle (pin currently 1)
    tog_ovf_en = 1'b0;
    step(16'h0000, 1'b0, 1'b1);
    chk("R8 disabled toggle", {15'd0, pin_out}, 16'd1);
    tog_ovf_en = 1'b1;
    step(16'h0000, 1'b0, 1'b1);
    chk("R8 toggle low", {15'd0, pin_out}, 16'd0);
    step(16'h0000, 1'b0, 1'b1);
    chk("R8 toggle high", {15'd0, pin_out}, 16'd1);

    // R9: priority, pin is 1
    out_act = 2'b11;
    wr(16'h1234);
    step(16'h1234, 1'b1, 1'b1);
    chk("R9 set beats toggle", {15'd0, pin_out}, 16'd1);
    out_act = 2'b10;
    step(16'h1234, 1'b1, 1'b1);
    chk("R9 clear beats toggle", {15'd0, pin_out}, 16'd0);
    out_act = 2'b00;
    step(16'h1234, 1'b1, 1'b1);
    chk("R9 none lets toggle", {15'd0, pin_out}, 16'd1);

    // R5: overflow toggle still works in capture mode
    mode_cmp = 1'b0;
    step(16'h0000, 1'b0, 1'b1);
    chk("R5 capture-mode toggle", {15'd0, pin_out}, 16'd0);

    report();
  end

endmodule